// File: doc/BRIEF.md
# Reloadable 16-bit Timer with Pulse Capture

This peripheral is a 16-bit up-counter paired with a 16-bit reload/capture register. A 4-bit register bus reaches both through four nibble windows. Writes fill the reload register one nibble at a time. The write to the top nibble commits all bits into the counter. Reads start at the top nibble, which freezes the lower bits so that a multi-read sequence returns one coherent value.

Four modes are selected by a 2-bit code:
- Free-running timer on a clock-enable from a power-of-two prescaler.
- Counter of selected edges on an external pin.
- Single-edge pulse-width capture.
- Double-edge capture that alternately measures high and low phases.

The pin passes through a two-flop synchroniser and is then sampled on prescaler ticks. Every overflow or capture raises a one-cycle interrupt pulse and sets a sticky flag. Software clears that flag by writing 0.

Top module: `cap_timer16`

## Requirements
- R1: After reset the counter, the reload register, `irq`, `irq_flag` and `bus_rdata` are all zero.
- R2: A write with `bus_addr[2]`=0 stores `bus_wdata` into reload nibble `bus_addr[1:0]`. Writes to nibbles 0..2 leave the counter unchanged. A write to nibble 3 also loads the counter with the full 16-bit reload value, taking the new top nibble.
- R3: A read pulse to nibble 3 returns the top nibble in `bus_rdata` one cycle later and freezes the lower 12 bits of the same source at that edge. Later reads of nibbles 0..2 return the frozen bits even if the counter has moved.
- R4: In timer mode (`mode`=0) the counter increments once per prescaler tick. On the increment from FFFF it reloads from the reload register and raises `irq` for exactly one cycle.
- R5: The prescaler issues one tick every 2^`pre_sel` clock cycles (`pre_sel`=0 gives a tick every cycle).
- R6: While `go`=0 the counter holds its value, except for a top-nibble write, and no `irq` is raised.
- R7: In event mode (`mode`=1) the counter increments once per selected pin edge: rising when `edge_sel`=1, falling when `edge_sel`=0. A pin change driven before clock edge k is counted at edge k+2.
- R8: In single-edge capture (`mode`=2, opening edge = `edge_sel` polarity) the counter counts ticks while the pin is at the opening level. On the closing edge it copies the pulse length in ticks into the reload register, clears to 0, raises `irq` and stays at 0 until the next opening edge.
- R9: In double-edge capture (`mode`=3) every pin edge copies the length in ticks of the phase just ended into the reload register, restarts the count and raises `irq`.
- R10: `irq_flag` sets with every `irq`. A `flag_wr` with `flag_wdata`=0 clears it, and with `flag_wdata`=1 it has no effect.
- R11: With `bus_addr[2]`=1, reads return the reload/capture register through the same nibble protocol, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Bit 2 selects the window (0 counter/reload, 1 capture view), bits 1:0 the nibble |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble, valid the cycle after `bus_rd` |
| ext_in | input | 1 | External event / pulse input, asynchronous |
| pre_sel | input | 3 | Prescaler exponent n, divide by 2^n |
| edge_sel | input | 1 | 1 rising, 0 falling selected / opening edge |
| mode | input | 2 | 0 timer, 1 event counter, 2 single capture, 3 double capture |
| go | input | 1 | Run enable |
| flag_wr | input | 1 | Sticky flag write strobe |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block at its defaults: 16-bit counter, 3-bit prescaler select and a two-stage synchroniser. With the 16-bit width, overflow is reached by preloading values a few counts below FFFF, so reload timing can be measured cycle by cycle. The 3-bit select lets divide-by-1 and divide-by-4 overflow intervals be compared directly. The two-stage synchroniser fixes the pin-to-count latency at a value the bench can probe, and capture results can be predicted exactly in clock cycles when ticks run every cycle.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
   typedef enum logic [1:0] {
      TM_TIMER   = 2'd0,
      TM_EVENT   = 2'd1,
      TM_CAP_ONE = 2'd2,
      TM_CAP_TWO = 2'd3
   } tmr_mode_e;
endpackage

// File: rtl/ctimer_prescale.sv
module ctimer_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("ctimer_prescale: SEL_W out of range");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < DIV_W; i++) mask[i] = (i < int'(sel));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/ctimer_edge.sv
module ctimer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic tick,
   output logic lvl_now,
   output logic lvl_prev,
   output logic edge_hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctimer_edge: at least two synchroniser stages required");
   end

   logic [STAGES-1:0] sync_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b0;
         else if (s == 0) sync_q[s] <= pin;
         else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   assign lvl_now = sync_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lvl_prev <= 1'b0;
      else if (tick) lvl_prev <= lvl_now;
   end

   assign edge_hit = tick && (lvl_now != lvl_prev);

   assert_edge_sampled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> (lvl_prev == $past(lvl_now)))
      else $error("edge sample not recorded");
endmodule

// File: rtl/ctimer_rdport.sv
module ctimer_rdport #(
   parameter int W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd,
   input  logic [$clog2(W/4)-1:0]     addr,
   input  logic [W-1:0]               src,
   output logic [3:0]                 rdata
);
   localparam int NIB = W / 4;
   localparam int AW  = $clog2(NIB);

   logic [W-5:0] snap_q;
   logic         top_rd;

   assign top_rd = rd && (addr == AW'(NIB - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
         rdata  <= '0;
      end else if (top_rd) begin
         snap_q <= src[W-5:0];
         rdata  <= src[W-1:W-4];
      end else if (rd) begin
         rdata  <= snap_q[{addr, 2'b00} +: 4];
      end
   end

   assert_snap_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !top_rd |=> $stable(snap_q))
      else $error("snapshot changed without a top-nibble read");
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 #(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [$clog2(CNT_W/4):0]      bus_addr,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [3:0]                    bus_wdata,
   output logic [3:0]                    bus_rdata,
   input  logic                          ext_in,
   input  logic [PRE_W-1:0]              pre_sel,
   input  logic                          edge_sel,
   input  logic [1:0]                    mode,
   input  logic                          go,
   input  logic                          flag_wr,
   input  logic                          flag_wdata,
   output logic                          irq,
   output logic                          irq_flag
);
   import ctimer_pkg::*;

   localparam int NIB     = CNT_W / 4;
   localparam int NA_W    = $clog2(NIB);
   localparam int TOP_NIB = NIB - 1;

   if (CNT_W % 4 != 0 || CNT_W < 8) begin : g_bad_width
      $error("cap_timer16: CNT_W must be a multiple of 4 and at least 8");
   end

   logic [CNT_W-1:0] count_q, load_q;
   logic             win_cap;
   logic [NA_W-1:0]  nib;
   logic             ld_wr, top_wr;
   logic             tick, lvl_now, lvl_prev, edge_hit;
   logic             open_e, close_e;
   logic             inc, wrap, capture, seed_one, seed_zero, ev;
   tmr_mode_e        md;

   assign win_cap = bus_addr[NA_W];
   assign nib     = bus_addr[NA_W-1:0];
   assign ld_wr   = bus_wr && !win_cap;
   assign top_wr  = ld_wr && (nib == NA_W'(TOP_NIB));
   assign md      = tmr_mode_e'(mode);

   ctimer_prescale #(.SEL_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(pre_sel), .tick(tick));

   ctimer_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(ext_in), .tick(tick),
      .lvl_now(lvl_now), .lvl_prev(lvl_prev), .edge_hit(edge_hit));

   assign open_e  = edge_hit && (lvl_now == edge_sel);
   assign close_e = edge_hit && (lvl_now != edge_sel);

   always_comb begin
      inc       = 1'b0;
      capture   = 1'b0;
      seed_one  = 1'b0;
      seed_zero = 1'b0;
      if (go) begin
         unique case (md)
            TM_TIMER: inc = tick;
            TM_EVENT: inc = open_e;
            TM_CAP_ONE: begin
               if (close_e) begin
                  capture   = 1'b1;
                  seed_zero = 1'b1;
               end else if (open_e) begin
                  seed_one  = 1'b1;
               end else begin
                  inc = tick && (lvl_prev == edge_sel);
               end
            end
            TM_CAP_TWO: begin
               if (edge_hit) begin
                  capture  = 1'b1;
                  seed_one = 1'b1;
               end else begin
                  inc = tick;
               end
            end
            default: inc = 1'b0;
         endcase
      end
   end

   assign wrap = inc && (count_q == '1);
   assign ev   = wrap || capture;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         count_q <= '0;
      else if (top_wr)    count_q <= {bus_wdata, load_q[CNT_W-5:0]};
      else if (seed_one)  count_q <= CNT_W'(1);
      else if (seed_zero) count_q <= '0;
      else if (wrap)      count_q <= load_q;
      else if (inc)       count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       load_q <= '0;
      else if (ld_wr)   load_q[{nib, 2'b00} +: 4] <= bus_wdata;
      else if (capture) load_q <= count_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         irq <= ev;
         if (ev)                         irq_flag <= 1'b1;
         else if (flag_wr && !flag_wdata) irq_flag <= 1'b0;
      end
   end

   ctimer_rdport #(.W(CNT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(nib),
      .src(win_cap ? load_q : count_q), .rdata(bus_rdata));

   assert_irq_needs_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(go))
      else $error("irq raised while stopped");

   assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!go && !top_wr) |=> (count_q == $past(count_q)))
      else $error("counter moved while stopped");

   assert_flag_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_flag)
      else $error("sticky flag missed an irq");

   assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(mode) == 2'd0 && !$past(bus_wr)) |-> (count_q == load_q))
      else $error("timer irq without reload");

   assert_capture_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(mode) == 2'd2 && $past(lvl_now) != $past(edge_sel) && !$past(bus_wr))
      |-> (count_q == '0))
      else $error("single capture did not clear counter");
endmodule

// File: tb/cap_timer16_tb_top.sv
module cap_timer16_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_wdata = '0;
   logic [3:0] bus_rdata;
   logic       ext_in = 1'b0;
   logic [2:0] pre_sel = '0;
   logic       edge_sel = 1'b1;
   logic [1:0] mode = '0;
   logic       go = 1'b0;
   logic       flag_wr = 1'b0, flag_wdata = 1'b0;
   logic       irq, irq_flag;

   int nvec = 0, nfail = 0, irq_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cap_timer16 dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in), .pre_sel(pre_sel),
      .edge_sel(edge_sel), .mode(mode), .go(go), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
      .irq(irq), .irq_flag(irq_flag));

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [3:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [3:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read16(input logic sel, output logic [15:0] v);
      logic [3:0] n;
      rd({sel, 2'd3}, n); v[15:12] = n;
      rd({sel, 2'd0}, n); v[3:0]   = n;
      rd({sel, 2'd1}, n); v[7:4]   = n;
      rd({sel, 2'd2}, n); v[11:8]  = n;
   endtask

   task automatic load16(input logic [15:0] v);
      wr(3'd0, v[3:0]); wr(3'd1, v[7:4]); wr(3'd2, v[11:8]); wr(3'd3, v[15:12]);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      chk("R1 irq", irq, 0);
      chk("R1 flag", irq_flag, 0);
      chk("R1 rdata", bus_rdata, 0);
      read16(1'b0, v); chk("R1 counter", v, 16'h0000);
      read16(1'b1, v); chk("R1 reload", v, 16'h0000);
   endtask

   task automatic t_load_protocol();
      logic [15:0] v;
      wr(3'd0, 4'hC); wr(3'd1, 4'hB); wr(3'd2, 4'hA);
      read16(1'b0, v); chk("R2 low nibbles keep counter", v, 16'h0000);
      wr(3'd3, 4'h9);
      read16(1'b0, v); chk("R2 top nibble commits", v, 16'h9ABC);
      read16(1'b1, v); chk("R11 capture view read", v, 16'h9ABC);
   endtask

   task automatic t_capture_window_write();
      logic [15:0] v;
      wr(3'd7, 4'h0); wr(3'd4, 4'h5);
      read16(1'b0, v); chk("R11 write ignored (counter)", v, 16'h9ABC);
      read16(1'b1, v); chk("R11 write ignored (reload)", v, 16'h9ABC);
   endtask

   task automatic t_stopped();
      logic [15:0] v;
      int c0 = irq_cnt;
      mode = 2'd0; pre_sel = 3'd0;
      repeat (30) @(negedge clk);
      read16(1'b0, v); chk("R6 counter holds", v, 16'h9ABC);
      chk("R6 no irq while stopped", irq_cnt, c0);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      int hit = 0;
      mode = 2'd0; pre_sel = 3'd0;
      load16(16'hFFFC);
      go = 1'b1;
      for (int i = 1; i <= 10 && hit == 0; i++) begin
         @(negedge clk);
         if (irq) begin hit = i; go = 1'b0; end
      end
      chk("R4 irq on wrap cycle", hit, 4);
      @(negedge clk);
      chk("R4 irq single cycle", irq, 0);
      read16(1'b0, v); chk("R4 reloaded value", v, 16'hFFFC);
      chk("R10 flag set by irq", irq_flag, 1);
   endtask

   task automatic t_presc(input logic [2:0] sel, input int exp);
      int n = 0;
      int guard = 0;
      mode = 2'd0; pre_sel = sel;
      load16(16'hFFF0);
      go = 1'b1;
      while (!irq && guard < 600) begin @(negedge clk); guard++; end
      do begin @(negedge clk); n++; end while (!irq && n < 600);
      go = 1'b0;
      chk("R5 overflow interval", n, exp);
      @(negedge clk);
   endtask

   task automatic t_flag();
      chk("R10 flag before write", irq_flag, 1);
      flag_wr = 1'b1; flag_wdata = 1'b1;
      @(negedge clk); flag_wr = 1'b0;
      chk("R10 write 1 no effect", irq_flag, 1);
      flag_wr = 1'b1; flag_wdata = 1'b0;
      @(negedge clk); flag_wr = 1'b0;
      chk("R10 write 0 clears", irq_flag, 0);
   endtask

   task automatic t_snapshot();
      logic [15:0] v;
      mode = 2'd0; pre_sel = 3'd0;
      load16(16'h0FFE);
      go = 1'b1;
      read16(1'b0, v);
      go = 1'b0;
      chk("R3 coherent snapshot", v, 16'h0FFE);
      read16(1'b0, v); chk("R3 counter after run", v, 16'h1002);
   endtask

   task automatic t_latency();
      logic [15:0] v;
      mode = 2'd1; edge_sel = 1'b1; pre_sel = 3'd0;
      load16(16'h0000);
      go = 1'b1;
      ext_in = 1'b1;
      repeat (2) @(negedge clk);
      read16(1'b0, v); chk("R7 not yet counted", v, 16'h0000);
      read16(1'b0, v); chk("R7 counted at third edge", v, 16'h0001);
      go = 1'b0; ext_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_event(input logic esel, input int pulses);
      logic [15:0] v;
      mode = 2'd1; edge_sel = esel; pre_sel = 3'd0;
      load16(16'h0000);
      go = 1'b1;
      for (int p = 0; p < pulses; p++) begin
         ext_in = 1'b1; repeat (3) @(negedge clk);
         ext_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      go = 1'b0;
      read16(1'b0, v); chk(esel ? "R7 rising edges" : "R7 falling edges", v, pulses);
   endtask

   task automatic t_single(input int h);
      logic [15:0] v;
      int c0 = irq_cnt;
      mode = 2'd2; edge_sel = 1'b1; pre_sel = 3'd0; go = 1'b1;
      ext_in = 1'b1; repeat (h) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
      read16(1'b1, v); chk("R8 captured width", v, h);
      read16(1'b0, v); chk("R8 counter cleared", v, 16'h0000);
      repeat (6) @(negedge clk);
      read16(1'b0, v); chk("R8 counter halted", v, 16'h0000);
      chk("R8 one irq per pulse", irq_cnt, c0 + 1);
   endtask

   task automatic t_dbl_phase(input logic lvl, input int dur, input int exp, input bit en);
      logic [15:0] v;
      ext_in = lvl;
      repeat (4) @(negedge clk);
      read16(1'b1, v);
      if (en) chk(lvl ? "R9 low phase captured" : "R9 high phase captured", v, exp);
      repeat (dur - 8) @(negedge clk);
   endtask

   task automatic t_double();
      mode = 2'd3; pre_sel = 3'd0; go = 1'b1;
      t_dbl_phase(1'b1, 12, 0, 1'b0);
      t_dbl_phase(1'b0, 15, 12, 1'b1);
      t_dbl_phase(1'b1, 20, 15, 1'b1);
      t_dbl_phase(1'b0, 13, 20, 1'b1);
      go = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_protocol();
      t_capture_window_write();
      t_stopped();
      t_wrap();
      t_presc(3'd0, 16);
      t_presc(3'd2, 64);
      t_flag();
      t_snapshot();
      t_latency();
      t_event(1'b1, 5);
      t_event(1'b0, 3);
      t_single(7);
      t_single(12);
      t_double();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nvec++; nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end
endmodule